// File: doc/BRIEF.md
# Partitionable Two-Way Cache

This block is a two-way set-associative cache whose two ways can be regrouped at run time. In unified mode both ways form one cache, which serves a single requester on port 0. In split mode each way becomes a private direct-mapped partition with its own request port, so two requesters look up in the same cycle without disturbing each other. A mode register, written through a one-cycle strobe, selects the grouping and steers addresses to ways and results back to ports.

Each request port takes an address and returns a hit flag and one data word one cycle later. Line fills come from the next memory level through a single refill port that names the requesting port, the set index, the tag and the full line. The cache does not fetch on a miss itself. The tag, index and offset split of the address does not depend on the mode.

Top module: `part_cache`

## Requirements
- R1: An address splits into the word offset (low OFF_W bits), the set index (next IDX_W bits) and the tag (remaining high bits), in both modes. A lookup hits only when tag and index match a valid line, and then returns the word that the offset selects.
- R2: A request on port p is answered by `rsp_vld[p]` exactly one cycle later, with `rsp_hit[p]` and `rsp_data[p]` valid in that same cycle. No response appears without a request, and a hit is never reported on a refused response.
- R3: In unified mode (`cfg_split`=0 written), port 0 searches both ways of the set, and a line filled through port 0 is found whichever way holds it.
- R4: In unified mode, a port 1 request is refused: the response has `rsp_refused`=1 and `rsp_hit`=0. A refill that names port 1 has no effect on the contents.
- R5: In split mode (`cfg_split`=1 written), port 0 searches only way 0 and port 1 searches only way 1. Both ports are answered in the same cycle, and a line filled for one port is never a hit on the other port.
- R6: In split mode, a refill for port p always writes way p at the given index, replacing the line resident there (direct-mapped behaviour).
- R7: In unified mode, a refill goes to an invalid way (way 0 first). If both ways are valid, it goes to the less recently used way. A port 0 hit and a refill each make the touched way the most recent, and a hit answered in the same cycle as a refill to that set counts before the refill chooses its way.
- R8: Any write of the mode register, even of the current value, invalidates every line and clears the recency state. A request issued in the same cycle as that write misses.
- R9: On a miss, `rsp_data` is zero.
- R10: After reset, the mode is unified, all lines are invalid and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_split | input | 1 | Mode value to write: 0 unified, 1 split |
| req_vld | input | 2 | Request valid, one bit per port |
| req_addr | input | 2 x ADDR_W | Request address per port |
| rsp_vld | output | 2 | Response valid per port |
| rsp_hit | output | 2 | Hit flag per port |
| rsp_refused | output | 2 | Request refused in the current mode |
| rsp_data | output | 2 x DATA_W | Selected word on hit, zero otherwise |
| rf_vld | input | 1 | Refill strobe |
| rf_port | input | 1 | Port the refill belongs to |
| rf_idx | input | IDX_W | Set index of the refill |
| rf_tag | input | ADDR_W-IDX_W-OFF_W | Tag of the refilled line |
| rf_line | input | DATA_W x 2^OFF_W | Line data, word k at bits [k*DATA_W +: DATA_W] |

## Verification
The assertions check the protocol properties on every cycle: the one-cycle response timing, refusal of port 1 in unified mode and never in split mode, zero data on a miss, and a miss for any request that meets a mode write. Which way a line lands in, the isolation between partitions, the recency choice when a hit and a refill collide on a set, and the word selection by offset all depend on stored contents. Only the bench's scenarios show these, by filling lines and then looking them up on both ports.

// File: rtl/part_cache_pkg.sv
package part_cache_pkg;
  typedef enum logic {
    MODE_UNIFIED = 1'b0,
    MODE_SPLIT   = 1'b1
  } pc_mode_e;
endpackage

// File: rtl/pc_way_ram.sv
// One way: tag and line storage in a single read-first RAM with a
// registered read port, shaped for block RAM inference.
module pc_way_ram #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 10,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  localparam int SETS  = 1 << IDX_W;
  localparam int ENT_W = TAG_W + LINE_W;

  logic [ENT_W-1:0] mem [SETS];
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_line};
    rd_q <= mem[rd_idx];
  end

  assign {rd_tag, rd_line} = rd_q;
endmodule

// File: rtl/pc_state.sv
// Valid bits and per-set recency, kept in flops so a mode write can
// clear them in one cycle.
module pc_state #(
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  fill_en,
  input  logic                  fill_way,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic                  touch_en,
  input  logic                  touch_way,
  input  logic [IDX_W-1:0]      touch_idx,
  input  logic [1:0][IDX_W-1:0] rd_idx,
  output logic [1:0]            rd_vld,
  output logic                  victim
);
  localparam int SETS = 1 << IDX_W;

  logic [1:0][SETS-1:0] vld_q;
  logic [SETS-1:0]      lru_q;   // way to replace next
  logic                 lru_eff;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
      lru_q <= '0;
    end else begin
      if (touch_en) lru_q[touch_idx] <= ~touch_way;
      if (fill_en) begin
        vld_q[fill_way][fill_idx] <= 1'b1;
        lru_q[fill_idx]           <= ~fill_way;
      end
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) rd_vld[w] <= 1'b0;
      else     rd_vld[w] <= vld_q[w][rd_idx[w]] & ~flush;
    end
  end

  // A hit answered this cycle on the same set counts before the fill.
  always_comb begin
    lru_eff = lru_q[fill_idx];
    if (touch_en && (touch_idx == fill_idx)) lru_eff = ~touch_way;
    if (!vld_q[0][fill_idx])      victim = 1'b0;
    else if (!vld_q[1][fill_idx]) victim = 1'b1;
    else                          victim = lru_eff;
  end
endmodule

// File: rtl/pc_lookup.sv
// Per-port tag compare and word select over the ways it may search.
module pc_lookup #(
  parameter int TAG_W  = 10,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 16,
  parameter int LINE_W = DATA_W * (2 ** OFF_W)
) (
  input  logic                   act,
  input  logic [1:0]             search,
  input  logic [1:0]             way_vld,
  input  logic [1:0][TAG_W-1:0]  way_tag,
  input  logic [1:0][LINE_W-1:0] way_line,
  input  logic [TAG_W-1:0]       tag,
  input  logic [OFF_W-1:0]       off,
  output logic                   hit,
  output logic                   hit_way,
  output logic [DATA_W-1:0]      data
);
  localparam int WORDS = 1 << OFF_W;

  logic [1:0]                   match;
  logic [WORDS-1:0][DATA_W-1:0] words;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign match[w] = act & search[w] & way_vld[w] & (way_tag[w] == tag);
  end

  assign hit     = |match;
  assign hit_way = match[1];
  assign words   = match[1] ? way_line[1] : way_line[0];
  assign data    = hit ? words[off] : '0;
endmodule

// File: rtl/part_cache.sv
module part_cache
  import part_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_wr,
  input  logic                               cfg_split,
  input  logic [1:0]                         req_vld,
  input  logic [1:0][ADDR_W-1:0]             req_addr,
  output logic [1:0]                         rsp_vld,
  output logic [1:0]                         rsp_hit,
  output logic [1:0]                         rsp_refused,
  output logic [1:0][DATA_W-1:0]             rsp_data,
  input  logic                               rf_vld,
  input  logic                               rf_port,
  input  logic [IDX_W-1:0]                   rf_idx,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0]      rf_tag,
  input  logic [DATA_W*(2**OFF_W)-1:0]       rf_line
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int NPORT  = 2;
  localparam int NWAY   = 2;

  // Mode register
  pc_mode_e mode_q;
  logic     is_split;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_UNIFIED;
    else if (cfg_wr) mode_q <= cfg_split ? MODE_SPLIT : MODE_UNIFIED;
  end
  assign is_split = (mode_q == MODE_SPLIT);

  // Address fields
  logic [NPORT-1:0][TAG_W-1:0] a_tag;
  logic [NPORT-1:0][IDX_W-1:0] a_idx;
  logic [NPORT-1:0][OFF_W-1:0] a_off;

  for (genvar p = 0; p < NPORT; p++) begin : g_split
    assign {a_tag[p], a_idx[p], a_off[p]} = req_addr[p];
  end

  // Way read steering: a way is read by its own port in split mode,
  // by port 0 otherwise.
  logic [NWAY-1:0][IDX_W-1:0] way_rd_idx;
  for (genvar w = 0; w < NWAY; w++) begin : g_steer
    assign way_rd_idx[w] = is_split ? a_idx[w] : a_idx[0];
  end

  // Request stage registers
  logic [NPORT-1:0]            p_vld_q;
  logic [NPORT-1:0]            p_ref_q;
  logic                        p_split_q;
  logic [NPORT-1:0][TAG_W-1:0] p_tag_q;
  logic [NPORT-1:0][OFF_W-1:0] p_off_q;
  logic [IDX_W-1:0]            p_idx0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld_q   <= '0;
      p_ref_q   <= '0;
      p_split_q <= 1'b0;
    end else begin
      p_vld_q   <= req_vld;
      p_ref_q   <= req_vld & (is_split ? 2'b00 : 2'b10);
      p_split_q <= is_split;
    end
  end

  always_ff @(posedge clk) begin
    p_tag_q  <= a_tag;
    p_off_q  <= a_off;
    p_idx0_q <= a_idx[0];
  end

  // Refill target
  logic fill_ok, fill_way, victim;
  assign fill_ok  = rf_vld & ~cfg_wr & (is_split | ~rf_port);
  assign fill_way = is_split ? rf_port : victim;

  // Way storage
  logic [NWAY-1:0][TAG_W-1:0]  way_tag;
  logic [NWAY-1:0][LINE_W-1:0] way_line;
  logic [NWAY-1:0]             way_vld;

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    pc_way_ram #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
    ) u_ram (
      .clk    (clk),
      .wr_en  (fill_ok && (fill_way == 1'(w))),
      .wr_idx (rf_idx),
      .wr_tag (rf_tag),
      .wr_line(rf_line),
      .rd_idx (way_rd_idx[w]),
      .rd_tag (way_tag[w]),
      .rd_line(way_line[w])
    );
  end

  // Per-port compare
  logic [NPORT-1:0]             hit_c;
  logic [NPORT-1:0]             hit_way_c;
  logic [NPORT-1:0][NWAY-1:0]   port_srch;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_srch[p] = p_ref_q[p] ? '0 :
                          (p_split_q ? NWAY'(1 << p) : '1);
    pc_lookup #(
      .TAG_W (TAG_W),
      .OFF_W (OFF_W),
      .DATA_W(DATA_W),
      .LINE_W(LINE_W)
    ) u_look (
      .act     (p_vld_q[p]),
      .search  (port_srch[p]),
      .way_vld (way_vld),
      .way_tag (way_tag),
      .way_line(way_line),
      .tag     (p_tag_q[p]),
      .off     (p_off_q[p]),
      .hit     (hit_c[p]),
      .hit_way (hit_way_c[p]),
      .data    (rsp_data[p])
    );
  end

  // Valid and recency state
  pc_state #(
    .IDX_W(IDX_W)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .flush    (cfg_wr),
    .fill_en  (fill_ok),
    .fill_way (fill_way),
    .fill_idx (rf_idx),
    .touch_en (hit_c[0] & ~p_split_q),
    .touch_way(hit_way_c[0]),
    .touch_idx(p_idx0_q),
    .rd_idx   (way_rd_idx),
    .rd_vld   (way_vld),
    .victim   (victim)
  );

  assign rsp_vld     = p_vld_q;
  assign rsp_hit     = hit_c;
  assign rsp_refused = p_ref_q;
endmodule

// File: rtl/part_cache_chk.sv
module part_cache_chk #(
  parameter int DATA_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_wr,
  input logic                   is_split,
  input logic [1:0]             req_vld,
  input logic [1:0]             rsp_vld,
  input logic [1:0]             rsp_hit,
  input logic [1:0]             rsp_refused,
  input logic [1:0][DATA_W-1:0] rsp_data
);
  for (genvar p = 0; p < 2; p++) begin : g_p
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
      req_vld[p] |=> rsp_vld[p]);                                   // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
      !req_vld[p] |=> !rsp_vld[p]);                                 // R2
    AST_HIT_NOT_REFUSED: assert property (@(posedge clk) disable iff (rst)
      rsp_hit[p] |-> (rsp_vld[p] && !rsp_refused[p]));              // R2
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
      !rsp_hit[p] |-> (rsp_data[p] == '0));                         // R9
    AST_SPLIT_SERVES: assert property (@(posedge clk) disable iff (rst)
      (req_vld[p] && is_split) |=> !rsp_refused[p]);                // R5
  end

  AST_PORT0_SERVED: assert property (@(posedge clk) disable iff (rst)
    req_vld[0] |=> !rsp_refused[0]);                                // R3
  AST_PORT1_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (req_vld[1] && !is_split) |=> (rsp_refused[1] && !rsp_hit[1])); // R4
  AST_CFG_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (rsp_hit == 2'b00));                                 // R8
endmodule

bind part_cache part_cache_chk #(.DATA_W(DATA_W)) u_part_cache_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .is_split   (is_split),
  .req_vld    (req_vld),
  .rsp_vld    (rsp_vld),
  .rsp_hit    (rsp_hit),
  .rsp_refused(rsp_refused),
  .rsp_data   (rsp_data)
);

// File: tb/test_part_cache.sv
`timescale 1ns/1ps
module test_part_cache;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int OFF_W  = 2;
  localparam int DATA_W = 16;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINE_W = DATA_W * WORDS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst;
  logic                   cfg_wr, cfg_split;
  logic [1:0]             req_vld;
  logic [1:0][ADDR_W-1:0] req_addr;
  logic [1:0]             rsp_vld, rsp_hit, rsp_refused;
  logic [1:0][DATA_W-1:0] rsp_data;
  logic                   rf_vld, rf_port;
  logic [IDX_W-1:0]       rf_idx;
  logic [TAG_W-1:0]       rf_tag;
  logic [LINE_W-1:0]      rf_line;

  part_cache #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) i_part_cache (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_split(cfg_split),
    .req_vld(req_vld), .req_addr(req_addr),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_refused(rsp_refused),
    .rsp_data(rsp_data),
    .rf_vld(rf_vld), .rf_port(rf_port), .rf_idx(rf_idx), .rf_tag(rf_tag),
    .rf_line(rf_line)
  );

  typedef struct {
    int               port;
    logic             hit;
    logic             refd;
    logic [DATA_W-1:0] data;
    string            req;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
    return {TAG_W'(tag), IDX_W'(idx), OFF_W'(off)};
  endfunction

  function automatic logic [LINE_W-1:0] mkl(input int base);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < WORDS; k++) l[k*DATA_W +: DATA_W] = DATA_W'(base + k);
    return l;
  endfunction

  // Monitor: compares every response against the oldest expectation.
  always @(negedge clk) begin
    if (!rst) begin
      for (int p = 0; p < 2; p++) begin
        if (rsp_vld[p]) begin
          exp_t e;
          n_chk++;
          if (q.size() == 0) begin
            n_fail++;
            $display("FAIL R2 port%0d unexpected response: actual vld=1 expected vld=0", p);
          end else begin
            e = q.pop_front();
            if (e.port != p || rsp_hit[p] !== e.hit || rsp_refused[p] !== e.refd ||
                rsp_data[p] !== e.data) begin
              n_fail++;
              $display("FAIL %s port%0d: actual port=%0d hit=%b ref=%b data=%h expected port=%0d hit=%b ref=%b data=%h",
                       e.req, p, p, rsp_hit[p], rsp_refused[p], rsp_data[p],
                       e.port, e.hit, e.refd, e.data);
            end
          end
        end
      end
    end
  end

  // Driver: one cycle of requests (and optional mode write), expectations queued.
  task automatic issue(input bit v0, input logic [ADDR_W-1:0] a0, input bit h0,
                       input logic [DATA_W-1:0] d0,
                       input bit v1, input logic [ADDR_W-1:0] a1, input bit h1,
                       input logic [DATA_W-1:0] d1, input bit r1,
                       input string rq, input bit do_cfg = 0, input bit cfg_val = 0);
    @(negedge clk);
    req_vld     = {v1, v0};
    req_addr[0] = a0;
    req_addr[1] = a1;
    cfg_wr      = do_cfg;
    cfg_split   = cfg_val;
    if (v0) q.push_back('{0, h0, 1'b0, d0, rq});
    if (v1) q.push_back('{1, h1, r1, d1, rq});
    @(posedge clk);
    #1;
    req_vld = '0;
    cfg_wr  = 1'b0;
  endtask

  task automatic refill(input bit port, input int idx, input int tag, input int base);
    @(negedge clk);
    rf_vld  = 1'b1;
    rf_port = port;
    rf_idx  = IDX_W'(idx);
    rf_tag  = TAG_W'(tag);
    rf_line = mkl(base);
    @(posedge clk);
    #1;
    rf_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual run still active, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; cfg_wr = 0; cfg_split = 0; req_vld = '0; req_addr = '0;
    rf_vld = 0; rf_port = 0; rf_idx = '0; rf_tag = '0; rf_line = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (rsp_vld !== 2'b00 || rsp_hit !== 2'b00 || rsp_refused !== 2'b00) begin
      n_fail++;
      $display("FAIL R10 reset outputs: actual vld=%b hit=%b ref=%b expected 00 00 00",
               rsp_vld, rsp_hit, rsp_refused);
    end

    // Unified mode
    issue(1, mk(5,3,1), 0, 0, 1, mk(5,3,1), 0, 0, 1, "R4");      // miss, port 1 refused (R9)
    refill(0, 3, 5, 'h0500);
    issue(1, mk(5,3,0), 1, 'h0500, 0, '0, 0, 0, 0, "R1");
    issue(1, mk(5,3,3), 1, 'h0503, 0, '0, 0, 0, 0, "R9");
    issue(1, mk(5,4,0), 0, 0, 0, '0, 0, 0, 0, "R1");             // other index
    issue(1, mk(6,3,0), 0, 0, 0, '0, 0, 0, 0, "R1");             // other tag
    refill(0, 3, 6, 'h0600);
    issue(1, mk(6,3,2), 1, 'h0602, 0, '0, 0, 0, 0, "R3");
    issue(1, mk(5,3,1), 1, 'h0501, 0, '0, 0, 0, 0, "R3");
    refill(0, 3, 7, 'h0700);                                     // collides with hit above (R7)
    issue(1, mk(6,3,0), 0, 0, 0, '0, 0, 0, 0, "R7");
    issue(1, mk(5,3,2), 1, 'h0502, 0, '0, 0, 0, 0, "R7");
    issue(1, mk(7,3,3), 1, 'h0703, 0, '0, 0, 0, 0, "R7");
    refill(1, 8, 9, 'h0900);                                     // ignored in unified
    issue(1, mk(9,8,0), 0, 0, 1, mk(9,8,0), 0, 0, 1, "R4");

    // Switch to split mode
    issue(0, '0, 0, 0, 0, '0, 0, 0, 0, "R8", 1, 1);
    issue(1, mk(5,3,2), 0, 0, 1, mk(7,3,3), 0, 0, 0, "R8");
    refill(0, 2, 'hA, 'h0A00);
    refill(1, 2, 'hB, 'h0B00);
    issue(1, mk('hA,2,2), 1, 'h0A02, 1, mk('hA,2,2), 0, 0, 0, "R5");
    issue(1, mk('hB,2,1), 0, 0, 1, mk('hB,2,3), 1, 'h0B03, 0, "R5");
    refill(0, 2, 'hC, 'h0C00);
    issue(1, mk('hA,2,0), 0, 0, 1, mk('hB,2,0), 1, 'h0B00, 0, "R6");
    issue(1, mk('hC,2,1), 1, 'h0C01, 0, '0, 0, 0, 0, "R6");

    // Rewrite same mode with a request in the same cycle
    issue(0, '0, 0, 0, 1, mk('hB,2,1), 0, 0, 0, "R8", 1, 1);
    issue(0, '0, 0, 0, 1, mk('hB,2,1), 0, 0, 0, "R8");
    issue(1, mk('hC,2,1), 0, 0, 0, '0, 0, 0, 0, "R8");

    // Back to unified
    issue(0, '0, 0, 0, 0, '0, 0, 0, 0, "R8", 1, 0);
    issue(1, mk('hC,2,1), 0, 0, 1, mk('hC,2,1), 0, 0, 1, "R4");

    repeat (3) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 responses missing: actual %0d outstanding expected 0", q.size());
    end
    finish_run();
  end
endmodule